// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter

This block gathers interrupt requests for a processor core and hands them over one at a time. Three sources can get past any mask. A reset request is one. A non-maskable request is another. The third group is a set of maskable sources: three active-low external lines and four active-high internal pulses (serial receive, serial transmit, timer, UART). Each maskable source sets its own bit in a flag register. A request is offered only when the mask bit and a global enable are also set. The block chooses the most urgent pending request, latches it, and presents `irq_req` with a vector address. It keeps both steady until the core returns `irq_ack`.

Software reaches the flags, the mask and the global enable through a small register port. The core raises `core_busy` while a repeated or wait-stretched instruction runs, and no new maskable or non-maskable offer starts during that time. The control is a two-state machine. In state ARB_IDLE the block looks for a candidate. The transition ARB_IDLE to ARB_OFFER fires when a candidate exists and latches its slot. In ARB_OFFER the request is driven, and the transition ARB_OFFER to ARB_IDLE fires on `irq_ack`, which retires the taken source.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `irq_req` is 0 and the flag, mask and global-enable registers all read 0.
- R2: A falling edge on `ext_n[i]` sets flag bit i. Flag bits 0 to 2 are the external lines. The edge shows in the flag on the second clock edge after the first edge that samples the line low, because the line passes through two synchronizer stages first. A high pulse on `int_src[j]` sets flag bit 3+j at the next edge. The internal bits are 3 serial receive, 4 serial transmit, 5 timer and 6 UART.
- R3: A write to address 0 clears each flag bit whose write-data bit is 1. Bits written 0 are left unchanged. If a set from a source and a clear arrive in the same cycle, the set wins. Reads of address 0 or 3 return the flags.
- R4: A write to address 3 sets each flag bit whose write-data bit is 1.
- R5: A maskable source is offered only if its flag bit, its mask bit and the global enable are all 1. The mask is written and read at address 1. The global enable is bit 0 at address 2.
- R6: Priority from highest to lowest is: reset request, non-maskable request, maskable flag bit 0, and so on up to flag bit 6, which is lowest.
- R7: The vector equals VEC_BASE + 2*slot. Slot 0 is reset, slot 1 is non-maskable, and slot 2+i is flag bit i, so consecutive vectors are two words apart.
- R8: A pulse on `nmi_in` is held pending until it is taken. It is offered whatever the mask and global enable hold. A reset request is offered even while `core_busy` is 1.
- R9: While `core_busy` is 1, no non-maskable or maskable offer begins.
- R10: Once raised, `irq_req` and `irq_vec` stay fixed until `irq_ack` is seen. This holds even if a more urgent request arrives meanwhile.
- R11: When an offer is acknowledged, the taken flag bit or pending non-maskable request is cleared and the global enable goes to 0. This clear wins over a global-enable write in the same cycle.
- R12: The machine leaves ARB_IDLE for ARB_OFFER one clock after a candidate first exists, and returns to ARB_IDLE at the edge where `irq_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Reset request, highest priority |
| nmi_in | input | 1 | Non-maskable request pulse, active high |
| ext_n | input | N_EXT | External maskable lines, falling-edge triggered |
| int_src | input | N_INT | Internal maskable source pulses |
| core_busy | input | 1 | Core is in a multicycle instruction |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 clear, 1 mask, 2 enable, 3 set) |
| reg_wdata | input | N_EXT+N_INT | Register write data |
| reg_rdata | output | N_EXT+N_INT | Register read data for reg_addr |
| irq_req | output | 1 | Interrupt offered to the core |
| irq_vec | output | VEC_W | Vector address of the offered interrupt |
| irq_ack | input | 1 | Core accepts the offered interrupt |

## Verification
The hardest case is a held offer that must not move when a more urgent source turns up. To reach it, the bench leaves a low-priority UART offer unacknowledged and then fires the non-maskable input and a software flag set. It checks that the vector stays put and that the newcomers are served in order afterwards. The bench also lines up an acknowledge with a global-enable write in the same cycle, and a source pulse with a flag clear in the same cycle, to test both precedence rules. A reference model of the flags, synchronizer history and offer state is compared against the design on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_OFFER = 1'b1
    } arb_state_t;

    localparam logic [1:0] RA_FLAG_CLR = 2'd0;
    localparam logic [1:0] RA_MASK     = 2'd1;
    localparam logic [1:0] RA_GIE      = 2'd2;
    localparam logic [1:0] RA_FLAG_SET = 2'd3;

    localparam int SLOT_RESET = 0;
    localparam int SLOT_NMI   = 1;
    localparam int SLOT_MASK0 = 2;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    output logic fell
);
    localparam int HW = SYNC_STAGES + 1;

    logic [HW-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '1;
        else        hist_q <= {hist_q[HW-2:0], line_n};
    end

    // oldest synchronized sample high, newer one low
    assign fell = hist_q[HW-1] & ~hist_q[HW-2];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
#(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_set,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [N-1:0] wr_data,
    input  logic [N-1:0] take_clr,
    input  logic         take_any,
    output logic [N-1:0] flags,
    output logic [N-1:0] mask,
    output logic         gie,
    output logic [N-1:0] rd_data
);
    logic [N-1:0] sw_clr, sw_set;

    assign sw_clr = (wr_en && addr == RA_FLAG_CLR) ? wr_data : '0;
    assign sw_set = (wr_en && addr == RA_FLAG_SET) ? wr_data : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            mask  <= '0;
            gie   <= 1'b0;
        end else begin
            // sets beat clears
            flags <= (flags & ~sw_clr & ~take_clr) | src_set | sw_set;
            if (wr_en && addr == RA_MASK) mask <= wr_data;
            if (take_any)                        gie <= 1'b0;
            else if (wr_en && addr == RA_GIE)    gie <= wr_data[0];
        end
    end

    always_comb begin
        unique case (addr)
            RA_MASK: rd_data = mask;
            RA_GIE:  rd_data = N'(gie);
            default: rd_data = flags;
        endcase
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
#(
    parameter int N      = 7,
    parameter int SLOT_W = 4
) (
    input  logic              rst_req,
    input  logic              nmi_pend,
    input  logic              busy,
    input  logic              gie,
    input  logic [N-1:0]      pend,
    output logic              valid,
    output logic [SLOT_W-1:0] slot
);
    always_comb begin
        valid = 1'b0;
        slot  = '0;
        if (rst_req) begin
            valid = 1'b1;
            slot  = SLOT_W'(SLOT_RESET);
        end else if (!busy) begin
            if (nmi_pend) begin
                valid = 1'b1;
                slot  = SLOT_W'(SLOT_NMI);
            end else if (gie) begin
                // descending scan: lowest index ends up chosen
                for (int i = N - 1; i >= 0; i--) begin
                    if (pend[i]) begin
                        valid = 1'b1;
                        slot  = SLOT_W'(i + SLOT_MASK0);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N_EXT       = 3,
    parameter int N_INT       = 4,
    parameter int VEC_W       = 6,
    parameter int VEC_BASE    = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rst_req,
    input  logic                   nmi_in,
    input  logic [N_EXT-1:0]       ext_n,
    input  logic [N_INT-1:0]       int_src,
    input  logic                   core_busy,
    input  logic                   reg_we,
    input  logic [1:0]             reg_addr,
    input  logic [N_EXT+N_INT-1:0] reg_wdata,
    output logic [N_EXT+N_INT-1:0] reg_rdata,
    output logic                   irq_req,
    output logic [VEC_W-1:0]       irq_vec,
    input  logic                   irq_ack
);
    localparam int N_SRC  = N_EXT + N_INT;
    localparam int SLOT_W = $clog2(N_SRC + SLOT_MASK0);

    logic [N_EXT-1:0]  ext_fell;
    logic [N_SRC-1:0]  flags, mask, take_clr;
    logic              gie, nmi_q, take_nmi, taken;
    logic              cand_valid;
    logic [SLOT_W-1:0] cand_slot, slot_q, slot_d;
    arb_state_t        state_q, state_d;

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        irq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_n (ext_n[g]),
            .fell   (ext_fell[g])
        );
    end

    irq_flag_bank #(.N(N_SRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_set  ({int_src, ext_fell}),
        .wr_en    (reg_we),
        .addr     (reg_addr),
        .wr_data  (reg_wdata),
        .take_clr (take_clr),
        .take_any (taken),
        .flags    (flags),
        .mask     (mask),
        .gie      (gie),
        .rd_data  (reg_rdata)
    );

    irq_pick #(.N(N_SRC), .SLOT_W(SLOT_W)) u_pick (
        .rst_req  (rst_req),
        .nmi_pend (nmi_q),
        .busy     (core_busy),
        .gie      (gie),
        .pend     (flags & mask),
        .valid    (cand_valid),
        .slot     (cand_slot)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            slot_q  <= '0;
            nmi_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            nmi_q   <= (nmi_q & ~take_nmi) | nmi_in;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        taken   = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (cand_valid) begin
                    state_d = ARB_OFFER;
                    slot_d  = cand_slot;
                end
            end
            ARB_OFFER: begin
                if (irq_ack) begin
                    state_d = ARB_IDLE;
                    taken   = 1'b1;
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_req  = (state_q == ARB_OFFER);
        irq_vec  = VEC_W'(VEC_BASE) + VEC_W'({slot_q, 1'b0});
        take_nmi = taken && (slot_q == SLOT_W'(SLOT_NMI));
        for (int i = 0; i < N_SRC; i++)
            take_clr[i] = taken && (slot_q == SLOT_W'(i + SLOT_MASK0));
    end

    // R10
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !irq_ack |=> irq_req && $stable(irq_vec));

    // R9
    busy_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req && core_busy && !rst_req |=> !irq_req);

    // R11
    ack_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack |=> !gie);

    // R5
    gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) && slot_q >= SLOT_W'(SLOT_MASK0) |-> $past(gie));

    // R6
    reset_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) && slot_q != SLOT_W'(SLOT_RESET) |-> !$past(rst_req));
endmodule

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;
    localparam int N = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rst_req = 1'b0, nmi_in = 1'b0, core_busy = 1'b0;
    logic [2:0]   ext_n = 3'b111;
    logic [3:0]   int_src = 4'b0;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq_req, irq_ack = 1'b0;
    logic [5:0]   irq_vec;

    int checks = 0, fails = 0;
    string phase = "R1";

    always #2 clk = ~clk;

    irq_arbiter uut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_in(nmi_in),
        .ext_n(ext_n), .int_src(int_src), .core_busy(core_busy),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_ack(irq_ack)
    );

    // behavioural reference
    bit [N-1:0] m_flag = '0, m_mask = '0;
    bit         m_gie = 0, m_nmi = 0, m_offer = 0;
    int         m_slot = 0;
    bit [2:0]   m_s1 = '1, m_s2 = '1, m_s3 = '1;

    task automatic model_step();
        int cand;
        bit [N-1:0] clr, setv, tclr;
        bit [2:0] fall;
        bit tnmi, tany;
        clr  = (reg_we && reg_addr == 2'd0) ? reg_wdata : '0;
        setv = (reg_we && reg_addr == 2'd3) ? reg_wdata : '0;
        cand = -1;
        if (rst_req) cand = 0;
        else if (!core_busy) begin
            if (m_nmi) cand = 1;
            else if (m_gie)
                for (int i = N - 1; i >= 0; i--)
                    if (m_flag[i] && m_mask[i]) cand = i + 2;
        end
        tclr = '0; tnmi = 0; tany = 0;
        if (!m_offer) begin
            if (cand >= 0) begin m_offer = 1; m_slot = cand; end
        end else if (irq_ack) begin
            m_offer = 0; tany = 1;
            if (m_slot == 1) tnmi = 1;
            if (m_slot >= 2) tclr[m_slot-2] = 1'b1;
        end
        fall = m_s3 & ~m_s2;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_n;
        m_flag = (m_flag & ~clr & ~tclr) | {int_src, fall} | setv;
        m_nmi = (m_nmi & ~tnmi) | nmi_in;
        if (reg_we && reg_addr == 2'd1) m_mask = reg_wdata;
        if (tany) m_gie = 0;
        else if (reg_we && reg_addr == 2'd2) m_gie = reg_wdata[0];
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flag = '0; m_mask = '0; m_gie = 0; m_nmi = 0; m_offer = 0;
            m_slot = 0; m_s1 = '1; m_s2 = '1; m_s3 = '1;
        end else model_step();
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit [N-1:0] er;
        check(irq_req == m_offer, "irq_req", int'(irq_req), int'(m_offer));
        if (m_offer && irq_req)
            check(irq_vec == 6'(2 * m_slot), "irq_vec", int'(irq_vec), 2 * m_slot);
        er = (reg_addr == 2'd1) ? m_mask : (reg_addr == 2'd2) ? N'(m_gie) : m_flag;
        check(reg_rdata == er, "reg_rdata", int'(reg_rdata), int'(er));
    end

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic take();
        for (int k = 0; k < 20 && !irq_req; k++) tick();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        // R1 reset state on every register
        phase = "R1";
        reg_addr = 2'd0; tick(); reg_addr = 2'd1; tick(); reg_addr = 2'd2; tick();
        reg_addr = 2'd0;
        // R2 internal pulse and external falling edge
        phase = "R2";
        int_src = 4'b0010; tick(); int_src = 4'b0; tick(2);
        ext_n[2] = 1'b0; tick(3); ext_n[2] = 1'b1; tick(4);
        // R3 clear by write-one, zero writes ignored, set beats clear
        phase = "R3";
        wr(2'd0, 7'h00); tick();
        wr(2'd0, 7'h10); tick();
        int_src = 4'b0001; wr(2'd0, 7'h08); int_src = 4'b0; tick();
        // R4 software set
        phase = "R4";
        wr(2'd3, 7'h41); tick();
        // R5 mask and global enable gate
        phase = "R5";
        wr(2'd1, 7'h00); wr(2'd2, 7'h01); tick(3);
        wr(2'd1, 7'h40); take(); tick(2);
        // R6 R7 priority order and vector spacing
        phase = "R6";
        wr(2'd1, 7'h7F); wr(2'd2, 7'h01); take();
        phase = "R7";
        wr(2'd2, 7'h01); take();
        wr(2'd2, 7'h01); take();
        // R8 reset beats NMI, NMI needs no enable
        phase = "R8";
        nmi_in = 1'b1; rst_req = 1'b1; tick(); nmi_in = 1'b0;
        tick(2);
        rst_req = 1'b0; take(); take(); tick(2);
        // R9 busy defers, reset request does not wait
        phase = "R9";
        core_busy = 1'b1;
        wr(2'd3, 7'h02); wr(2'd2, 7'h01);
        nmi_in = 1'b1; tick(); nmi_in = 1'b0;
        tick(6);
        phase = "R8";
        rst_req = 1'b1; tick(2); rst_req = 1'b0; take();
        phase = "R9";
        tick(2);
        core_busy = 1'b0; take(); wr(2'd2, 7'h01); take(); tick(2);
        // R10 R12 held offer with a more urgent arrival
        phase = "R10";
        wr(2'd3, 7'h40); wr(2'd2, 7'h01); tick();
        nmi_in = 1'b1; tick(); nmi_in = 1'b0;
        wr(2'd3, 7'h01); tick(4);
        phase = "R12";
        take(); take(); tick(2);
        // R11 acknowledge wins over same-cycle enable write
        phase = "R11";
        wr(2'd2, 7'h01);
        for (int k = 0; k < 20 && !irq_req; k++) tick();
        irq_ack = 1'b1; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 7'h01;
        tick();
        irq_ack = 1'b0; reg_we = 1'b0;
        tick(3);
        reg_addr = 2'd0; tick(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule